// File: doc/BRIEF.md
# Split-Tenure Bus Address Master

This block runs the address half of a processor bus whose address and data phases are arbitrated and completed separately. It serves one internal requester. When a transfer arrives on the request port, the block stores the address, type, size and burst flag. It then asks the bus arbiter for ownership. It starts the address tenure only when it holds a grant and sees that no other master is driving the shared busy line.

During the tenure the block sends a one-cycle start strobe. It drives the stored address and qualifiers and holds the busy line asserted until a slave acknowledges. Next it drives busy negated for one cycle and looks at the retry line. If retry is asserted, the same transfer goes back to arbitration with its attributes unchanged. If retry is not asserted, the requester gets a single-cycle completion pulse and the busy driver is released.

Every shared bus line is active low. Each line has its own output-enable so it can be wired to a tri-state pad. The data tenure, snooping, slave behaviour and the arbiter are outside this block.

Top module: `addr_tenure_master`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release: `bus_req_n_o` is 1, `start_n_o` is 1, `start_oe_o`, `busy_oe_o` and `attr_oe_o` are 0, `done_o` is 0 and `req_ready_o` is 1.
- R2: `req_ready_o` is 1 only while the block is idle. A cycle with `req_valid_i` and `req_ready_o` both high stores the attributes. From the next cycle `bus_req_n_o` is held at 0 until the grant is qualified.
- R3: No tenure starts while `grant_n_i` is 1.
- R4: No tenure starts while `busy_n_i` is 0, even if `grant_n_i` is 0.
- R5: A qualified grant, meaning `grant_n_i`=0 and `busy_n_i`=1 at a clock edge while requesting, makes `start_n_o` 0 with `start_oe_o`=1 for exactly the next cycle. In that same cycle `bus_req_n_o` returns to 1.
- R6: `busy_oe_o`=1 and `busy_n_o`=0 from the start cycle through the cycle in which `ack_n_i`=0 is sampled. The acknowledge can arrive in the start cycle itself.
- R7: In the cycle after the acknowledge, busy is driven negated (`busy_oe_o`=1, `busy_n_o`=1). In the cycle after that, `busy_oe_o` is 0.
- R8: `retry_n_i` is sampled in the cycle after the acknowledge. If it is 0, `done_o` stays 0 and the next cycle has `bus_req_n_o`=0. The same address and attributes are reused on the repeated tenure.
- R9: If `retry_n_i` is 1 in that cycle, `done_o` is 1 for exactly the following cycle. The block is idle after that.
- R10: While `attr_oe_o` is 1 (start through acknowledge), `addr_o`, `ttype_o` and `tsize_o` equal the stored values. `burst_n_o` is 0 exactly when the stored burst flag is 1 (a four-double-word burst).
- R11: Request-port activity outside idle is ignored. `req_ready_o` stays 0 and the driven attributes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid_i | input | 1 | Requester offers a transfer |
| req_addr_i | input | ADDR_W | Transfer address |
| req_ttype_i | input | TT_W | Transfer type code |
| req_tsize_i | input | SZ_W | Transfer size code |
| req_burst_i | input | 1 | 1 = four-double-word burst |
| req_ready_o | output | 1 | Block is idle and accepts a transfer |
| done_o | output | 1 | One-cycle pulse when the address tenure completes without retry |
| bus_req_n_o | output | 1 | Bus request, active low |
| grant_n_i | input | 1 | Bus grant, active low |
| busy_n_i | input | 1 | Sensed address-bus busy, active low |
| ack_n_i | input | 1 | Address acknowledge from a slave, active low |
| retry_n_i | input | 1 | Address retry, active low |
| start_n_o | output | 1 | Transfer-start strobe, active low |
| start_oe_o | output | 1 | Drive enable for the start strobe |
| busy_n_o | output | 1 | Driven address-bus busy, active low |
| busy_oe_o | output | 1 | Drive enable for busy |
| addr_o | output | ADDR_W | Driven address |
| ttype_o | output | TT_W | Driven transfer type |
| tsize_o | output | SZ_W | Driven transfer size |
| burst_n_o | output | 1 | Burst qualifier, active low |
| attr_oe_o | output | 1 | Drive enable for address, type, size and burst |

## Verification
The bench uses the default widths: 32-bit address, 5-bit type and 4-bit size. These widths let the bench drive full-range addresses such as all-ones and alternating patterns, and distinct type and size codes. A corrupted or truncated attribute field would therefore show up on the pins. The sequences cover several cases: grant held off, grant present while another master holds busy, an acknowledge in the start cycle, a late acknowledge, a retry followed by a clean second tenure, and request-port activity during a tenure.

// File: rtl/atm_pkg.sv
package atm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ASK    = 3'd1,
    ST_START  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_NEGATE = 3'd4,
    ST_FINISH = 3'd5
  } atm_state_e;

  function automatic logic in_tenure(input atm_state_e s);
    return (s == ST_START) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/atm_attr_hold.sv
module atm_attr_hold #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5,
  parameter int SZ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TT_W-1:0]   ttype_i,
  input  logic [SZ_W-1:0]   tsize_i,
  input  logic              burst_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TT_W-1:0]   ttype_o,
  output logic [SZ_W-1:0]   tsize_o,
  output logic              burst_o
);

  localparam int HOLD_W = ADDR_W + TT_W + SZ_W + 1;

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i) begin
      hold_d = {addr_i, ttype_i, tsize_i, burst_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign {addr_o, ttype_o, tsize_o, burst_o} = hold_q;

endmodule

// File: rtl/atm_ctrl.sv
module atm_ctrl
  import atm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic       grant_n_i,
  input  logic       busy_n_i,
  input  logic       ack_n_i,
  input  logic       retry_n_i,
  output logic       load_o,
  output atm_state_e state_o
);

  atm_state_e state_q;
  atm_state_e state_d;
  logic       grant_ok;
  logic       ack_seen;
  logic       retry_seen;

  assign grant_ok   = !grant_n_i && busy_n_i;
  assign ack_seen   = !ack_n_i;
  assign retry_seen = !retry_n_i;
  assign load_o     = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) state_d = ST_ASK;
      end
      ST_ASK: begin
        if (grant_ok) state_d = ST_START;
      end
      ST_START, ST_HOLD: begin
        if (ack_seen) state_d = ST_NEGATE;
        else          state_d = ST_HOLD;
      end
      ST_NEGATE: begin
        if (retry_seen) state_d = ST_ASK;
        else            state_d = ST_FINISH;
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/atm_pin_drv.sv
module atm_pin_drv
  import atm_pkg::*;
(
  input  atm_state_e state_i,
  input  logic       burst_i,
  output logic       req_ready_o,
  output logic       done_o,
  output logic       bus_req_n_o,
  output logic       start_n_o,
  output logic       start_oe_o,
  output logic       busy_n_o,
  output logic       busy_oe_o,
  output logic       burst_n_o,
  output logic       attr_oe_o
);

  always_comb begin
    req_ready_o = (state_i == ST_IDLE);
    done_o      = (state_i == ST_FINISH);
    bus_req_n_o = !(state_i == ST_ASK);
    start_n_o   = !(state_i == ST_START);
    start_oe_o  = (state_i == ST_START);
    attr_oe_o   = in_tenure(state_i);
    busy_oe_o   = in_tenure(state_i) || (state_i == ST_NEGATE);
    busy_n_o    = !in_tenure(state_i);
    burst_n_o   = !(burst_i && in_tenure(state_i)) || !attr_oe_o;
  end

endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master
  import atm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5,
  parameter int SZ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TT_W-1:0]   req_ttype_i,
  input  logic [SZ_W-1:0]   req_tsize_i,
  input  logic              req_burst_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              bus_req_n_o,
  input  logic              grant_n_i,
  input  logic              busy_n_i,
  input  logic              ack_n_i,
  input  logic              retry_n_i,
  output logic              start_n_o,
  output logic              start_oe_o,
  output logic              busy_n_o,
  output logic              busy_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TT_W-1:0]   ttype_o,
  output logic [SZ_W-1:0]   tsize_o,
  output logic              burst_n_o,
  output logic              attr_oe_o
);

  atm_state_e state;
  logic       load;
  logic       burst_q;

  atm_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .grant_n_i   (grant_n_i),
    .busy_n_i    (busy_n_i),
    .ack_n_i     (ack_n_i),
    .retry_n_i   (retry_n_i),
    .load_o      (load),
    .state_o     (state)
  );

  atm_attr_hold #(
    .ADDR_W (ADDR_W),
    .TT_W   (TT_W),
    .SZ_W   (SZ_W)
  ) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .addr_i  (req_addr_i),
    .ttype_i (req_ttype_i),
    .tsize_i (req_tsize_i),
    .burst_i (req_burst_i),
    .addr_o  (addr_o),
    .ttype_o (ttype_o),
    .tsize_o (tsize_o),
    .burst_o (burst_q)
  );

  atm_pin_drv i_pins (
    .state_i     (state),
    .burst_i     (burst_q),
    .req_ready_o (req_ready_o),
    .done_o      (done_o),
    .bus_req_n_o (bus_req_n_o),
    .start_n_o   (start_n_o),
    .start_oe_o  (start_oe_o),
    .busy_n_o    (busy_n_o),
    .busy_oe_o   (busy_oe_o),
    .burst_n_o   (burst_n_o),
    .attr_oe_o   (attr_oe_o)
  );

endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              bus_req_n_o,
  input logic              grant_n_i,
  input logic              busy_n_i,
  input logic              ack_n_i,
  input logic              start_n_o,
  input logic              start_oe_o,
  input logic              busy_n_o,
  input logic              busy_oe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              attr_oe_o
);

  // R3 and R4: a start follows a cycle that requested and saw a qualified grant
  assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n_o |-> $past(!bus_req_n_o && !grant_n_i && busy_n_i));

  // R5: the start strobe lasts one cycle and is driven
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n_o |=> start_n_o);
  assert_start_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n_o |-> (start_oe_o && bus_req_n_o));

  // R6: busy is driven asserted while attributes are on the bus
  assert_busy_in_tenure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    attr_oe_o |-> (busy_oe_o && !busy_n_o));

  // R7: the negated-busy cycle is followed by release
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe_o && busy_n_o) |=> !busy_oe_o);

  // R7: busy negation comes only after an acknowledge
  assert_negate_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe_o && busy_n_o) |-> $past(!ack_n_i && attr_oe_o));

  // R9: completion pulse is one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: address holds across the tenure
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_oe_o && $past(attr_oe_o)) |-> $stable(addr_o));

  // R11: not ready while requesting or driving
  assert_not_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n_o || busy_oe_o) |-> !req_ready_o);

endmodule

bind addr_tenure_master atm_checker #(.ADDR_W(ADDR_W)) i_atm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .bus_req_n_o (bus_req_n_o),
  .grant_n_i   (grant_n_i),
  .busy_n_i    (busy_n_i),
  .ack_n_i     (ack_n_i),
  .start_n_o   (start_n_o),
  .start_oe_o  (start_oe_o),
  .busy_n_o    (busy_n_o),
  .busy_oe_o   (busy_oe_o),
  .addr_o      (addr_o),
  .attr_oe_o   (attr_oe_o)
);

// File: tb/test_addr_tenure_master.sv
`timescale 1ns/1ps
module test_addr_tenure_master;

  localparam int ADDR_W = 32;
  localparam int TT_W   = 5;
  localparam int SZ_W   = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic [TT_W-1:0]   req_ttype_i;
  logic [SZ_W-1:0]   req_tsize_i;
  logic              req_burst_i;
  logic              req_ready_o;
  logic              done_o;
  logic              bus_req_n_o;
  logic              grant_n_i;
  logic              busy_n_i;
  logic              ack_n_i;
  logic              retry_n_i;
  logic              start_n_o;
  logic              start_oe_o;
  logic              busy_n_o;
  logic              busy_oe_o;
  logic [ADDR_W-1:0] addr_o;
  logic [TT_W-1:0]   ttype_o;
  logic [SZ_W-1:0]   tsize_o;
  logic              burst_n_o;
  logic              attr_oe_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int done_count = 0;

  // reference model: phase 0 idle, 1 asking, 2 start, 3 holding, 4 negating, 5 finished
  int m_phase;
  logic [ADDR_W-1:0] m_addr;
  logic [TT_W-1:0]   m_tt;
  logic [SZ_W-1:0]   m_sz;
  logic              m_burst;

  addr_tenure_master #(.ADDR_W(ADDR_W), .TT_W(TT_W), .SZ_W(SZ_W)) i_addr_tenure_master (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_ttype_i(req_ttype_i), .req_tsize_i(req_tsize_i), .req_burst_i(req_burst_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .bus_req_n_o(bus_req_n_o),
    .grant_n_i(grant_n_i), .busy_n_i(busy_n_i), .ack_n_i(ack_n_i), .retry_n_i(retry_n_i),
    .start_n_o(start_n_o), .start_oe_o(start_oe_o), .busy_n_o(busy_n_o),
    .busy_oe_o(busy_oe_o), .addr_o(addr_o), .ttype_o(ttype_o), .tsize_o(tsize_o),
    .burst_n_o(burst_n_o), .attr_oe_o(attr_oe_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
    end else begin
      case (m_phase)
        0: if (req_valid_i) begin
             m_addr = req_addr_i; m_tt = req_ttype_i; m_sz = req_tsize_i;
             m_burst = req_burst_i; m_phase = 1;
           end
        1: if (!grant_n_i && busy_n_i) m_phase = 2;
        2, 3: m_phase = (!ack_n_i) ? 4 : 3;
        4: m_phase = (!retry_n_i) ? 1 : 5;
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic drive;
    drive = (m_phase == 2) || (m_phase == 3);
    chk("R2", "req_ready", 64'(req_ready_o), 64'(m_phase == 0));
    chk("R2", "bus_req_n", 64'(bus_req_n_o), 64'(m_phase != 1));
    chk("R5", "start_n",   64'(start_n_o),   64'(m_phase != 2));
    chk("R5", "start_oe",  64'(start_oe_o),  64'(m_phase == 2));
    chk("R6", "busy_oe",   64'(busy_oe_o),   64'(drive || m_phase == 4));
    if (busy_oe_o) chk("R7", "busy_n", 64'(busy_n_o), 64'(!drive));
    chk("R9", "done",      64'(done_o),      64'(m_phase == 5));
    chk("R10", "attr_oe",  64'(attr_oe_o),   64'(drive));
    if (drive) begin
      chk("R10", "addr",  64'(addr_o),    64'(m_addr));
      chk("R10", "ttype", 64'(ttype_o),   64'(m_tt));
      chk("R10", "tsize", 64'(tsize_o),   64'(m_sz));
      chk("R10", "burst_n", 64'(burst_n_o), 64'(!m_burst));
    end
    if (done_o) done_count++;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic offer(input logic [ADDR_W-1:0] a, input logic [TT_W-1:0] t,
                       input logic [SZ_W-1:0] s, input logic b);
    req_valid_i = 1'b1; req_addr_i = a; req_ttype_i = t; req_tsize_i = s; req_burst_i = b;
    step(1);
    req_valid_i = 1'b0; req_addr_i = ~a; req_ttype_i = ~t; req_tsize_i = ~s; req_burst_i = ~b;
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0; req_ttype_i = '0;
    req_tsize_i = '0; req_burst_i = 1'b0;
    grant_n_i = 1'b1; busy_n_i = 1'b1; ack_n_i = 1'b1; retry_n_i = 1'b1;
    #1;
    chk("R1", "bus_req_n in reset", 64'(bus_req_n_o), 64'd1);
    chk("R1", "oe in reset", 64'({start_oe_o, busy_oe_o, attr_oe_o, done_o}), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    chk("R1", "ready after reset", 64'(req_ready_o), 64'd1);
    chk("R1", "start_n after reset", 64'(start_n_o), 64'd1);

    // R2/R3: plain transfer, grant held off two cycles, late acknowledge
    offer(32'hFFFF_FFFF, 5'h0A, 4'h8, 1'b0);
    step(2);
    chk("R3", "no start without grant", 64'(start_n_o), 64'd1);
    grant_n_i = 1'b0;
    step(1);
    grant_n_i = 1'b1;
    step(2);
    ack_n_i = 1'b0;
    step(1);
    ack_n_i = 1'b1;
    step(3);
    chk("R9", "one completion", 64'(done_count), 64'd1);

    // R4: grant present while another master holds busy
    offer(32'hA5A5_5A5A, 5'h12, 4'h2, 1'b0);
    grant_n_i = 1'b0; busy_n_i = 1'b0;
    step(3);
    chk("R4", "no start while busy held", 64'(start_oe_o), 64'd0);
    busy_n_i = 1'b1;
    step(1);
    grant_n_i = 1'b1;
    ack_n_i = 1'b0;
    step(1);
    ack_n_i = 1'b1;
    step(3);

    // R6/R10: burst with acknowledge in the start cycle; R11 request during tenure
    offer(32'h1234_5678, 5'h1F, 4'h0, 1'b1);
    grant_n_i = 1'b0;
    step(1);
    grant_n_i = 1'b1;
    ack_n_i = 1'b0;
    req_valid_i = 1'b1;
    step(1);
    chk("R11", "ready low in tenure", 64'(req_ready_o), 64'd0);
    ack_n_i = 1'b1;
    step(1);
    req_valid_i = 1'b0;
    step(2);

    // R8: retry, then second tenure with same attributes
    offer(32'h0000_0001, 5'h05, 4'hF, 1'b1);
    grant_n_i = 1'b0;
    step(1);
    grant_n_i = 1'b1;
    req_valid_i = 1'b1;
    step(1);
    ack_n_i = 1'b0;
    step(1);
    ack_n_i = 1'b1; retry_n_i = 1'b0;
    step(1);
    retry_n_i = 1'b1;
    chk("R8", "no done on retry", 64'(done_o), 64'd0);
    chk("R8", "re-request", 64'(bus_req_n_o), 64'd0);
    req_valid_i = 1'b0;
    step(2);
    grant_n_i = 1'b0;
    step(1);
    grant_n_i = 1'b1;
    chk("R8", "same address", 64'(addr_o), 64'h0000_0001);
    ack_n_i = 1'b0;
    step(1);
    ack_n_i = 1'b1;
    step(3);
    chk("R9", "total completions", 64'(done_count), 64'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule